// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the synchronized clock and data line levels of an I2C/SMBus controller and raises one sticky timeout error flag when the bus breaks a timing limit. It runs two independent checks. The primary check uses a single 12-bit threshold in one of two modes. In clock-low mode it detects a clock line that is held low too long. In idle mode it detects a bus on which both lines have stayed high long enough to count as free. The extended check adds up the cycles in which the controller itself stretches the clock low, and keeps that total for the whole of one transfer.

The controller feeds in the sampled line levels, a strobe that is high on every cycle it holds the clock low, and a one-cycle frame pulse at each START and each STOP. Software-side logic writes each check's settings through a write strobe. While a check is enabled, its threshold and mode are frozen and only its enable bit accepts a write. The error flag stays set until a clear pulse. An idle indication reports when idle mode has reached its limit.

Top module: `smbus_tmo_monitor`

## Requirements
- R1: After reset, timeoutFlag and idleSeen are 0, both checks are disabled, and both thresholds and the mode select are 0.
- R2: In clock-low mode (cfgPrimIdle written 0) with threshold A, timeoutFlag goes to 1 on the clock edge that samples sclIn low for the (A+1)*2048-th consecutive cycle, and not before.
- R3: In idle mode (cfgPrimIdle written 1) with threshold A, timeoutFlag goes to 1 on the edge that samples sclIn and sdaIn both high for the (A+1)*4-th consecutive cycle.
- R4: The primary count restarts from zero on any cycle in which the watched condition does not hold. It is held at zero while the primary check is disabled.
- R5: While the primary enable is 1, a primary write changes only the enable. The threshold and mode fields of that write are ignored.
- R6: With threshold B, the extended check sets timeoutFlag on the edge where the number of cycles sampled with stretchActive high reaches (B+1)*2048. The count adds up over separate stretch intervals and holds its value through cycles without stretching.
- R7: A xferFrame pulse clears the extended count. A stretch cycle that comes with a frame pulse is not counted. The count is also held at zero while the extended check is disabled.
- R8: While the extended enable is 1, an extended write changes only the enable. Its threshold field is ignored.
- R9: timeoutFlag stays 1 until a flagClr pulse. If flagClr and a new expiry fall in the same cycle, the flag stays 1.
- R10: Each count stops at its limit, so one violation sets the flag only once. The same condition cannot set the flag again until its count has been cleared.
- R11: idleSeen is 1 exactly while the primary check is enabled in idle mode and its count sits at the limit. It is 0 in clock-low mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized clock line level |
| sdaIn | input | 1 | Synchronized data line level |
| stretchActive | input | 1 | High on each cycle the controller holds the clock low |
| xferFrame | input | 1 | One-cycle pulse at START or STOP |
| flagClr | input | 1 | One-cycle pulse that clears timeoutFlag |
| cfgPrimWr | input | 1 | Write strobe for the primary settings |
| cfgPrimEnable | input | 1 | Primary enable value to write |
| cfgPrimIdle | input | 1 | Mode to write: 0 clock-low, 1 idle |
| cfgPrimThresh | input | 12 | Primary threshold A to write |
| cfgExtWr | input | 1 | Write strobe for the extended settings |
| cfgExtEnable | input | 1 | Extended enable value to write |
| cfgExtThresh | input | 12 | Extended threshold B to write |
| timeoutFlag | output | 1 | Sticky timeout error flag |
| idleSeen | output | 1 | Idle limit reached in idle mode |

## Verification
Several rules are checked on every cycle. Each count stays within its limit. A write made while a check is enabled leaves that check's limit unchanged. A disabled primary check or a frame pulse leaves its count at zero, and the extended count does not move on a cycle without stretching. The flag holds until a clear, and it only rises when a count stands at its limit. Other behaviour only the bench scenarios can show: the exact cycle of each expiry, adding up across split stretch intervals, expiry winning over a same-cycle clear, and that a locked write really leaves the old mode and threshold in force.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

  // Per-cycle commands from the control to the counter datapath.
  typedef struct packed {
    logic primClr;
    logic primInc;
    logic extClr;
    logic extInc;
  } ctrl_strb_t;

endpackage

// File: rtl/smb_tmo_counters.sv
module smb_tmo_counters
  import smb_tmo_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  input  logic [CNT_W-1:0] primLimit,
  input  logic [CNT_W-1:0] extLimit,
  output logic [CNT_W-1:0] primCnt,
  output logic [CNT_W-1:0] extCnt,
  output logic             primHit,
  output logic             primSat,
  output logic             extHit,
  output logic             extSat
);

  localparam int NUM_CNT = 2;

  logic [NUM_CNT-1:0]            clrVec;
  logic [NUM_CNT-1:0]            incVec;
  logic [NUM_CNT-1:0][CNT_W-1:0] limVec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVec;
  logic [NUM_CNT-1:0]            hitVec;
  logic [NUM_CNT-1:0]            satVec;

  assign clrVec = {strb.extClr, strb.primClr};
  assign incVec = {strb.extInc, strb.primInc};
  assign limVec = {extLimit, primLimit};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cntQ <= '0;
      else if (clrVec[i]) cntQ <= '0;
      else if (incVec[i]) cntQ <= cntQ + CNT_W'(1);
    end

    assign cntVec[i] = cntQ;
    assign hitVec[i] = (cntQ == limVec[i] - CNT_W'(1));
    assign satVec[i] = (cntQ == limVec[i]);
  end

  assign primCnt = cntVec[0];
  assign extCnt  = cntVec[1];
  assign primHit = hitVec[0];
  assign primSat = satVec[0];
  assign extHit  = hitVec[1];
  assign extSat  = satVec[1];

endmodule

// File: rtl/smb_tmo_ctrl.sv
module smb_tmo_ctrl
  import smb_tmo_pkg::*;
#(
  parameter int THR_W      = 12,
  parameter int LOW_SHIFT  = 11,
  parameter int IDLE_SHIFT = 2,
  parameter int CNT_W      = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             stretchActive,
  input  logic             xferFrame,
  input  logic             flagClr,
  input  logic             cfgPrimWr,
  input  logic             cfgPrimEnable,
  input  logic             cfgPrimIdle,
  input  logic [THR_W-1:0] cfgPrimThresh,
  input  logic             cfgExtWr,
  input  logic             cfgExtEnable,
  input  logic [THR_W-1:0] cfgExtThresh,
  input  logic             primHit,
  input  logic             primSat,
  input  logic             extHit,
  input  logic             extSat,
  output ctrl_strb_t       strb,
  output logic [CNT_W-1:0] primLimit,
  output logic [CNT_W-1:0] extLimit,
  output logic             primEn,
  output logic             extEn,
  output logic             timeoutFlag,
  output logic             idleSeen
);

  logic             primIdle;
  logic [THR_W-1:0] primThr;
  logic [THR_W-1:0] extThr;
  logic [THR_W:0]   primSpan;
  logic [THR_W:0]   extSpan;
  logic             primCond;
  logic             primExpire;
  logic             extExpire;

  // Settings: threshold and mode are written only while their check is off.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primEn   <= 1'b0;
      primIdle <= 1'b0;
      primThr  <= '0;
    end else if (cfgPrimWr) begin
      primEn <= cfgPrimEnable;
      if (!primEn) begin
        primIdle <= cfgPrimIdle;
        primThr  <= cfgPrimThresh;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extEn  <= 1'b0;
      extThr <= '0;
    end else if (cfgExtWr) begin
      extEn <= cfgExtEnable;
      if (!extEn) extThr <= cfgExtThresh;
    end
  end

  assign primSpan  = {1'b0, primThr} + (THR_W+1)'(1);
  assign extSpan   = {1'b0, extThr} + (THR_W+1)'(1);
  assign primLimit = primIdle ? (CNT_W'(primSpan) << IDLE_SHIFT)
                              : (CNT_W'(primSpan) << LOW_SHIFT);
  assign extLimit  = CNT_W'(extSpan) << LOW_SHIFT;

  assign primCond = primIdle ? (sclIn & sdaIn) : ~sclIn;

  always_comb begin
    strb.primClr = ~primEn | ~primCond;
    strb.primInc = ~strb.primClr & ~primSat;
    strb.extClr  = ~extEn | xferFrame;
    strb.extInc  = ~strb.extClr & stretchActive & ~extSat;
  end

  assign primExpire = strb.primInc & primHit;
  assign extExpire  = strb.extInc & extHit;

  // Expiry has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        timeoutFlag <= 1'b0;
    else if (primExpire || extExpire) timeoutFlag <= 1'b1;
    else if (flagClr)                 timeoutFlag <= 1'b0;
  end

  assign idleSeen = primEn & primIdle & primSat;

endmodule

// File: rtl/smbus_tmo_monitor.sv
module smbus_tmo_monitor
  import smb_tmo_pkg::*;
#(
  parameter int THR_W      = 12,
  parameter int LOW_SHIFT  = 11,
  parameter int IDLE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             stretchActive,
  input  logic             xferFrame,
  input  logic             flagClr,
  input  logic             cfgPrimWr,
  input  logic             cfgPrimEnable,
  input  logic             cfgPrimIdle,
  input  logic [THR_W-1:0] cfgPrimThresh,
  input  logic             cfgExtWr,
  input  logic             cfgExtEnable,
  input  logic [THR_W-1:0] cfgExtThresh,
  output logic             timeoutFlag,
  output logic             idleSeen
);

  localparam int CNT_W = THR_W + 1 + LOW_SHIFT;

  ctrl_strb_t       strb;
  logic [CNT_W-1:0] primLimit;
  logic [CNT_W-1:0] extLimit;
  logic [CNT_W-1:0] primCnt;
  logic [CNT_W-1:0] extCnt;
  logic             primHit;
  logic             primSat;
  logic             extHit;
  logic             extSat;
  logic             primEn;
  logic             extEn;

  smb_tmo_ctrl #(
    .THR_W(THR_W), .LOW_SHIFT(LOW_SHIFT), .IDLE_SHIFT(IDLE_SHIFT), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .stretchActive(stretchActive), .xferFrame(xferFrame), .flagClr(flagClr),
    .cfgPrimWr(cfgPrimWr), .cfgPrimEnable(cfgPrimEnable), .cfgPrimIdle(cfgPrimIdle),
    .cfgPrimThresh(cfgPrimThresh), .cfgExtWr(cfgExtWr), .cfgExtEnable(cfgExtEnable),
    .cfgExtThresh(cfgExtThresh), .primHit(primHit), .primSat(primSat),
    .extHit(extHit), .extSat(extSat), .strb(strb), .primLimit(primLimit),
    .extLimit(extLimit), .primEn(primEn), .extEn(extEn),
    .timeoutFlag(timeoutFlag), .idleSeen(idleSeen)
  );

  smb_tmo_counters #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rstN(rstN), .strb(strb), .primLimit(primLimit), .extLimit(extLimit),
    .primCnt(primCnt), .extCnt(extCnt), .primHit(primHit), .primSat(primSat),
    .extHit(extHit), .extSat(extSat)
  );

endmodule

// File: rtl/smb_tmo_checker.sv
module smb_tmo_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             stretchActive,
  input logic             xferFrame,
  input logic             flagClr,
  input logic             cfgPrimWr,
  input logic             cfgExtWr,
  input logic             primEn,
  input logic             extEn,
  input logic [CNT_W-1:0] primLimit,
  input logic [CNT_W-1:0] extLimit,
  input logic [CNT_W-1:0] primCnt,
  input logic [CNT_W-1:0] extCnt,
  input logic             primSat,
  input logic             extSat,
  input logic             timeoutFlag,
  input logic             idleSeen
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!timeoutFlag && !idleSeen));

  a_r4_disabled_clear: assert property (@(posedge clk) disable iff (!rstN)
    !primEn |=> (primCnt == '0));

  a_r5_prim_lock: assert property (@(posedge clk) disable iff (!rstN)
    (primEn && cfgPrimWr) |=> $stable(primLimit));

  a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rstN)
    (extEn && !stretchActive && !xferFrame) |=> $stable(extCnt));

  a_r7_frame_reset: assert property (@(posedge clk) disable iff (!rstN)
    xferFrame |=> (extCnt == '0));

  a_r8_ext_lock: assert property (@(posedge clk) disable iff (!rstN)
    (extEn && cfgExtWr) |=> $stable(extLimit));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr) |=> timeoutFlag);

  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (primSat || extSat));

  a_r10_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (primCnt <= primLimit) && (extCnt <= extLimit));

endmodule

bind smbus_tmo_monitor smb_tmo_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .stretchActive(stretchActive), .xferFrame(xferFrame),
  .flagClr(flagClr), .cfgPrimWr(cfgPrimWr), .cfgExtWr(cfgExtWr),
  .primEn(primEn), .extEn(extEn), .primLimit(primLimit), .extLimit(extLimit),
  .primCnt(primCnt), .extCnt(extCnt), .primSat(primSat), .extSat(extSat),
  .timeoutFlag(timeoutFlag), .idleSeen(idleSeen)
);

// File: tb/smbus_tmo_monitor_tb.sv
`timescale 1ns/1ps
module smbus_tmo_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b0;
  logic        stretchActive = 1'b0;
  logic        xferFrame = 1'b0;
  logic        flagClr = 1'b0;
  logic        cfgPrimWr = 1'b0;
  logic        cfgPrimEnable = 1'b0;
  logic        cfgPrimIdle = 1'b0;
  logic [11:0] cfgPrimThresh = '0;
  logic        cfgExtWr = 1'b0;
  logic        cfgExtEnable = 1'b0;
  logic [11:0] cfgExtThresh = '0;
  logic        timeoutFlag;
  logic        idleSeen;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  smbus_tmo_monitor dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .stretchActive(stretchActive), .xferFrame(xferFrame), .flagClr(flagClr),
    .cfgPrimWr(cfgPrimWr), .cfgPrimEnable(cfgPrimEnable), .cfgPrimIdle(cfgPrimIdle),
    .cfgPrimThresh(cfgPrimThresh), .cfgExtWr(cfgExtWr), .cfgExtEnable(cfgExtEnable),
    .cfgExtThresh(cfgExtThresh), .timeoutFlag(timeoutFlag), .idleSeen(idleSeen)
  );

  typedef struct packed {
    logic        scl;
    logic        sda;
    logic        stretch;
    logic        frame;
    logic        clr;
    logic [15:0] cycles;
    logic        expFlag;
    logic        expIdle;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // Primary in idle mode with A=1 (limit 8); extended enabled with B=0 (limit 2048).
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'd7,   1'b0,1'b0,4'd3},  // R3 one cycle short
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'd1,   1'b1,1'b1,4'd3},  // R3 exact expiry, R11 idle up
    '{1'b1,1'b0,1'b0,1'b0,1'b0,16'd1,   1'b1,1'b0,4'd11}, // R11 drops, R9 flag held
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'd7,   1'b1,1'b0,4'd4},  // R4 restarted count
    '{1'b1,1'b1,1'b0,1'b0,1'b1,16'd1,   1'b1,1'b1,4'd9},  // R9 expiry beats clear
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,   1'b0,1'b0,4'd9},  // R9 clear
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd1000,1'b0,1'b0,4'd6},  // R6 first interval
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'd500, 1'b0,1'b0,4'd6},  // R6 gap
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd1047,1'b0,1'b0,4'd6},  // R6 total 2047
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'd10,  1'b0,1'b0,4'd6},  // R6 gap
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd1,   1'b1,1'b0,4'd6},  // R6 total 2048
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,   1'b0,1'b0,4'd9},  // R9 clear
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd100, 1'b0,1'b0,4'd10}, // R10 no second report
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,   1'b0,1'b0,4'd7},  // R7 frame
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd2047,1'b0,1'b0,4'd7},  // R7 fresh count
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd1,   1'b1,1'b0,4'd7},  // R7 expiry after frame
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,   1'b0,1'b0,4'd9},  // R9 clear
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,   1'b0,1'b0,4'd7},  // R7 frame
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd2000,1'b0,1'b0,4'd7},  // R7 partial
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'd1,   1'b0,1'b0,4'd7},  // R7 frame drops stretch cycle
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd2000,1'b0,1'b0,4'd7},  // R7 would exceed without reset
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd48,  1'b1,1'b0,4'd7},  // R7 exact 2048 since frame
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,   1'b0,1'b0,4'd9}   // R9 clear
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writePrim(input logic en, input logic idle, input logic [11:0] thr);
    cfgPrimEnable = en; cfgPrimIdle = idle; cfgPrimThresh = thr; cfgPrimWr = 1'b1;
    run(1);
    cfgPrimWr = 1'b0;
  endtask

  task automatic writeExt(input logic en, input logic [11:0] thr);
    cfgExtEnable = en; cfgExtThresh = thr; cfgExtWr = 1'b1;
    run(1);
    cfgExtWr = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    run(1);
    flagClr = 1'b0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    run(3);
    check("R1 flag in reset", timeoutFlag, 1'b0);
    check("R1 idle in reset", idleSeen, 1'b0);
    rstN = 1'b1;
    run(1);
    check("R1 flag after reset", timeoutFlag, 1'b0);

    // Vector table
    writePrim(1'b1, 1'b1, 12'd1);
    writeExt(1'b1, 12'd0);
    for (int i = 0; i < NV; i++) begin
      sclIn = VECS[i].scl; sdaIn = VECS[i].sda;
      stretchActive = VECS[i].stretch; xferFrame = VECS[i].frame; flagClr = VECS[i].clr;
      run(int'(VECS[i].cycles));
      check($sformatf("R%0d vector %0d flag", VECS[i].req, i), timeoutFlag, VECS[i].expFlag);
      check($sformatf("R%0d vector %0d idle", VECS[i].req, i), idleSeen, VECS[i].expIdle);
    end
    stretchActive = 1'b0; xferFrame = 1'b0; flagClr = 1'b0;
    sclIn = 1'b1; sdaIn = 1'b0;

    // R2 clock-low mode, A=0 -> 2048 cycles
    writePrim(1'b0, 1'b0, 12'd0);
    writePrim(1'b1, 1'b0, 12'd0);
    writeExt(1'b0, 12'd0);
    sclIn = 1'b0;
    run(2047);
    check("R2 one cycle short", timeoutFlag, 1'b0);
    run(1);
    check("R2 exact expiry", timeoutFlag, 1'b1);
    check("R11 no idle in clock-low mode", idleSeen, 1'b0);

    // R10 saturated count reports nothing more
    pulseClr();
    check("R10 clear at saturation", timeoutFlag, 1'b0);
    run(3000);
    check("R10 no repeat report", timeoutFlag, 1'b0);

    // R4 restart on clock high
    sclIn = 1'b1; run(1);
    sclIn = 1'b0; run(1000);
    sclIn = 1'b1; run(1);
    sclIn = 1'b0; run(1500);
    check("R4 no sum across high pulse", timeoutFlag, 1'b0);
    run(547);
    check("R4 one short after restart", timeoutFlag, 1'b0);
    run(1);
    check("R4 expiry after restart", timeoutFlag, 1'b1);
    pulseClr();

    // R5 lock: idle mode with A=3 would fire at 16 cycles
    sclIn = 1'b1;
    writePrim(1'b1, 1'b1, 12'd3);
    sdaIn = 1'b1;
    run(20);
    check("R5 mode change ignored", timeoutFlag, 1'b0);
    check("R5 idle not seen", idleSeen, 1'b0);
    sdaIn = 1'b0; sclIn = 1'b0;
    run(2048);
    check("R5 old threshold kept", timeoutFlag, 1'b1);
    pulseClr();
    sclIn = 1'b1;
    writePrim(1'b0, 1'b0, 12'd0);
    sclIn = 1'b0;
    run(3000);
    check("R5 enable still writable", timeoutFlag, 1'b0);
    sclIn = 1'b1;

    // R8 extended lock
    writeExt(1'b1, 12'd0);
    writeExt(1'b1, 12'd7);
    stretchActive = 1'b1;
    run(2047);
    check("R8 one short", timeoutFlag, 1'b0);
    run(1);
    check("R8 old threshold kept", timeoutFlag, 1'b1);
    stretchActive = 1'b0;
    pulseClr();
    writeExt(1'b0, 12'd0);
    stretchActive = 1'b1;
    run(3000);
    check("R8 extended disabled", timeoutFlag, 1'b0);
    stretchActive = 1'b0;

    finish();
  end

endmodule